// File: doc/BRIEF.md
# One-Wire Bus Master Slot Engine

This block drives a single open-drain one-wire bus and carries out one low-level bus operation per command: a reset followed by a presence check, a slot that writes a one, a slot that writes a zero, or a slot that reads one bit back. The pad is controlled through a drive-low enable, and the line level comes back through a two-stage synchronizer. All bus timing is counted in microsecond ticks, which are derived from the system clock through a prescaler set by `CLK_HZ`.

Higher layers issue a two-bit opcode together with a one-cycle start strobe. They then wait for the one-cycle done pulse and read the result bit and the fault flag. Both stay valid until the next accepted start. The engine refuses to reset a bus that is already held low. It also flags a bus that is still low when the reset window ends. A read bit is decided by the moment the line returns high, not by a single fixed sample.

Top module: `onewire_slot_engine`

## Requirements
- R1: After reset, busy, done, resultBit, busFault and lineDriveLow are all 0. While idle, the pad is never driven low.
- R2: Opcode 2'd1 (write one) drives the line low for T_LOW1 µs. The done pulse then follows T_SLOT − T_LOW1 + T_REC µs after release.
- R3: Opcode 2'd2 (write zero) drives the line low for T_LOW0 µs. The done pulse then follows T_SLOT − T_LOW0 + T_REC µs after release.
- R4: Opcode 2'd3 (read) drives the line low for T_LOWR µs. The done pulse follows T_SLOT µs after the slot began.
- R5: A read returns resultBit 1 when the line is seen high before T_RDV µs have passed since the slot began.
- R6: A read returns resultBit 0 when the line stays low until T_RDV µs or later. The engine stops watching the line at T_RDV + 2 µs.
- R7: Opcode 2'd0 (reset) drives the line low for T_RSTL µs. It samples the line T_PDH + T_PDL/2 µs after release, and the done pulse follows T_RSTH µs after release. A low sample gives resultBit 0, which means a device answered.
- R8: A reset with no device answering returns resultBit 1 and busFault 0.
- R9: If the line is low when a reset is accepted, the engine never drives the pad. It ends within a few clocks with busFault 1 and resultBit 1 (presence invalid).
- R10: If the line is still low T_RSTH µs after the reset release, busFault is 1.
- R11: busy is 1 from the cycle after an accepted start through the done cycle. done lasts exactly one clock and falls together with busy.
- R12: A start strobe that arrives while busy is ignored. The current operation keeps its timing, and no second operation follows.
- R13: resultBit and busFault hold their values while idle, and both clear when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStrobe | input | 1 | One-cycle command start |
| opcode | input | 2 | 0 reset, 1 write one, 2 write zero, 3 read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| resultBit | output | 1 | Read bit or presence result (0 = device present) |
| busFault | output | 1 | Bus found stuck low around a reset |
| lineDriveLow | output | 1 | Pad pull-down enable |
| lineIn | input | 1 | Raw line level from the pad |

## Verification
The hardest cases to reach are the two stuck-bus faults, because each needs the line to be low at a moment when the engine itself is not pulling it down. The bench models the bus as a wired-AND of the engine's pull-down and a device pull-down. Its device model starts acting on the engine's own pad edges. For the stuck-bus checks, it either holds the line low before the reset command is issued, or it answers the reset with a presence pulse that lasts past the end of the reset window. Read decisions are driven the same way: the device holds the line low for a chosen number of microseconds from the slot's falling edge, on each side of the T_RDV boundary.

// File: rtl/onewire_pkg.sv
package onewire_pkg;

  typedef enum logic [1:0] {
    OP_RESET  = 2'd0,
    OP_WRITE1 = 2'd1,
    OP_WRITE0 = 2'd2,
    OP_READ   = 2'd3
  } owOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTime;
    logic clearRes;
    logic loadBit;
    logic bitVal;
    logic raiseFault;
    logic driveLow;
  } owCtrl_t;

endpackage

// File: rtl/onewire_datapath.sv
module onewire_datapath
  import onewire_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int CNT_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  owCtrl_t          ctrl,
  input  logic             lineIn,
  output logic             lineSync,
  output logic [CNT_W-1:0] usCount,
  output logic             lineDriveLow,
  output logic             resultBit,
  output logic             busFault
);

  localparam int DIV   = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [1:0]       syncQ;
  logic [PRE_W-1:0] preCount;
  logic             usTick;

  // two-stage synchronizer, idle line reads high
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], lineIn};
  end
  assign lineSync = syncQ[1];

  // microsecond prescaler, realigned on every timer clear
  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clrTime)             preCount <= '0;
    else if (preCount == PRE_W'(DIV - 1))  preCount <= '0;
    else                                   preCount <= preCount + 1'b1;
  end
  assign usTick = (preCount == PRE_W'(DIV - 1));

  // elapsed microseconds, saturating
  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clrTime)        usCount <= '0;
    else if (usTick && !(&usCount))   usCount <= usCount + 1'b1;
  end

  // registered pad enable
  always_ff @(posedge clk) begin
    if (!rstN) lineDriveLow <= 1'b0;
    else       lineDriveLow <= ctrl.driveLow;
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultBit <= 1'b0;
      busFault  <= 1'b0;
    end else begin
      if (ctrl.clearRes) begin
        resultBit <= 1'b0;
        busFault  <= 1'b0;
      end
      if (ctrl.loadBit)    resultBit <= ctrl.bitVal;
      if (ctrl.raiseFault) busFault  <= 1'b1;
    end
  end

endmodule

// File: rtl/onewire_control.sv
module onewire_control
  import onewire_pkg::*;
#(
  parameter int T_RSTL = 480,
  parameter int T_RSTH = 480,
  parameter int T_PDH  = 15,
  parameter int T_PDL  = 60,
  parameter int T_SLOT = 60,
  parameter int T_LOW1 = 6,
  parameter int T_LOW0 = 60,
  parameter int T_LOWR = 6,
  parameter int T_RDV  = 15,
  parameter int T_REC  = 5,
  parameter int CNT_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStrobe,
  input  logic [1:0]       opcode,
  input  logic             lineSync,
  input  logic [CNT_W-1:0] usCount,
  output owCtrl_t          ctrl,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] LIM_RSTL  = CNT_W'(T_RSTL);
  localparam logic [CNT_W-1:0] LIM_RSTH  = CNT_W'(T_RSTH);
  localparam logic [CNT_W-1:0] LIM_PSAMP = CNT_W'(T_PDH + T_PDL / 2);
  localparam logic [CNT_W-1:0] LIM_SLOT  = CNT_W'(T_SLOT);
  localparam logic [CNT_W-1:0] LIM_LOW1  = CNT_W'(T_LOW1);
  localparam logic [CNT_W-1:0] LIM_LOW0  = CNT_W'(T_LOW0);
  localparam logic [CNT_W-1:0] LIM_LOWR  = CNT_W'(T_LOWR);
  localparam logic [CNT_W-1:0] LIM_RDV   = CNT_W'(T_RDV);
  localparam logic [CNT_W-1:0] LIM_RDTO  = CNT_W'(T_RDV + 2);
  localparam logic [CNT_W-1:0] LIM_REC1  = CNT_W'(T_SLOT - T_LOW1 + T_REC);
  localparam logic [CNT_W-1:0] LIM_REC0  = CNT_W'(T_SLOT - T_LOW0 + T_REC);

  typedef enum logic [3:0] {
    S_IDLE, S_PRECHK, S_RSTLOW, S_PRESWAIT, S_RSTEND,
    S_SLOTLOW, S_WRREC, S_RDSAMP, S_RDWAIT, S_FINISH
  } state_e;

  state_e           state, nxt;
  owOp_e            opReg;
  logic [CNT_W-1:0] lowLim, recLim;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      opReg <= OP_RESET;
    end else begin
      state <= nxt;
      if (state == S_IDLE && startStrobe) opReg <= owOp_e'(opcode);
    end
  end

  always_comb begin
    case (opReg)
      OP_WRITE1: lowLim = LIM_LOW1;
      OP_WRITE0: lowLim = LIM_LOW0;
      default:   lowLim = LIM_LOWR;
    endcase
    recLim = (opReg == OP_WRITE1) ? LIM_REC1 : LIM_REC0;
  end

  always_comb begin
    nxt  = state;
    ctrl = '0;
    case (state)
      S_IDLE: if (startStrobe) begin
        ctrl.clrTime  = 1'b1;
        ctrl.clearRes = 1'b1;
        nxt = (owOp_e'(opcode) == OP_RESET) ? S_PRECHK : S_SLOTLOW;
      end
      S_PRECHK: begin
        if (!lineSync) begin
          ctrl.loadBit    = 1'b1;
          ctrl.bitVal     = 1'b1;
          ctrl.raiseFault = 1'b1;
          nxt = S_FINISH;
        end else begin
          ctrl.clrTime = 1'b1;
          nxt = S_RSTLOW;
        end
      end
      S_RSTLOW: begin
        ctrl.driveLow = 1'b1;
        if (usCount >= LIM_RSTL) begin
          ctrl.clrTime = 1'b1;
          nxt = S_PRESWAIT;
        end
      end
      S_PRESWAIT: if (usCount >= LIM_PSAMP) begin
        ctrl.loadBit = 1'b1;
        ctrl.bitVal  = lineSync;
        nxt = S_RSTEND;
      end
      S_RSTEND: if (usCount >= LIM_RSTH) begin
        ctrl.raiseFault = !lineSync;
        nxt = S_FINISH;
      end
      S_SLOTLOW: begin
        ctrl.driveLow = 1'b1;
        if (usCount >= lowLim) begin
          if (opReg == OP_READ) nxt = S_RDSAMP;
          else begin
            ctrl.clrTime = 1'b1;
            nxt = S_WRREC;
          end
        end
      end
      S_WRREC: if (usCount >= recLim) nxt = S_FINISH;
      S_RDSAMP: begin
        if (lineSync) begin
          ctrl.loadBit = 1'b1;
          ctrl.bitVal  = (usCount < LIM_RDV);
          nxt = S_RDWAIT;
        end else if (usCount >= LIM_RDTO) begin
          ctrl.loadBit = 1'b1;
          ctrl.bitVal  = 1'b0;
          nxt = S_RDWAIT;
        end
      end
      S_RDWAIT: if (usCount >= LIM_SLOT) nxt = S_FINISH;
      S_FINISH: nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FINISH);

endmodule

// File: rtl/onewire_slot_engine.sv
module onewire_slot_engine
  import onewire_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int T_RSTL = 480,
  parameter int T_RSTH = 480,
  parameter int T_PDH  = 15,
  parameter int T_PDL  = 60,
  parameter int T_SLOT = 60,
  parameter int T_LOW1 = 6,
  parameter int T_LOW0 = 60,
  parameter int T_LOWR = 6,
  parameter int T_RDV  = 15,
  parameter int T_REC  = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startStrobe,
  input  logic [1:0] opcode,
  output logic       busy,
  output logic       done,
  output logic       resultBit,
  output logic       busFault,
  output logic       lineDriveLow,
  input  logic       lineIn
);

  localparam int MAX_US = T_RSTL + T_RSTH + T_SLOT + T_REC + T_RDV + 4;
  localparam int CNT_W  = $clog2(MAX_US + 1);

  owCtrl_t          ctrl;
  logic             lineSync;
  logic [CNT_W-1:0] usCount;

  onewire_control #(
    .T_RSTL(T_RSTL), .T_RSTH(T_RSTH), .T_PDH(T_PDH), .T_PDL(T_PDL),
    .T_SLOT(T_SLOT), .T_LOW1(T_LOW1), .T_LOW0(T_LOW0), .T_LOWR(T_LOWR),
    .T_RDV(T_RDV), .T_REC(T_REC), .CNT_W(CNT_W)
  ) u_control (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .opcode(opcode),
    .lineSync(lineSync), .usCount(usCount), .ctrl(ctrl),
    .busy(busy), .done(done)
  );

  onewire_datapath #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .lineIn(lineIn),
    .lineSync(lineSync), .usCount(usCount), .lineDriveLow(lineDriveLow),
    .resultBit(resultBit), .busFault(busFault)
  );

endmodule

// File: rtl/onewire_slot_checker.sv
module onewire_slot_checker (
  input logic clk,
  input logic rstN,
  input logic startStrobe,
  input logic busy,
  input logic done,
  input logic resultBit,
  input logic busFault,
  input logic lineDriveLow
);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_with_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> !lineDriveLow);

  assert_busy_ignores_start_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && startStrobe) |=> busy);

  assert_results_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startStrobe) |=> ($stable(resultBit) && $stable(busFault)));

endmodule

bind onewire_slot_engine onewire_slot_checker u_checker (
  .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .busy(busy),
  .done(done), .resultBit(resultBit), .busFault(busFault),
  .lineDriveLow(lineDriveLow)
);

// File: tb/onewire_slot_engine_bench.sv
module onewire_slot_engine_bench;

  localparam int US = 4;  // clocks per microsecond at CLK_HZ = 4 MHz

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startStrobe = 1'b0;
  logic [1:0] opcode = 2'd0;
  logic busy, done, resultBit, busFault, drv, lineIn;
  logic devLow = 1'b0;

  int errors = 0;
  int checks = 0;
  int mLow, mTot, mDone, mBusyStart, mFaultStart, mBitStart;

  always #5 clk = ~clk;
  assign lineIn = !(drv || devLow);

  onewire_slot_engine #(.CLK_HZ(4_000_000)) u_onewire_slot_engine (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .opcode(opcode),
    .busy(busy), .done(done), .resultBit(resultBit), .busFault(busFault),
    .lineDriveLow(drv), .lineIn(lineIn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic near(input string req, input string what, input int act,
                      input int exp, input int tol);
    chk((act >= exp - tol) && (act <= exp + tol), req, what, act, exp);
  endtask

  // devMode 0: none, 1: hold low from slot fall, 2: presence after release
  task automatic runOp(input logic [1:0] op, input int devMode, input int holdUs,
                       input int delayUs, input int lenUs, input int injectCyc);
    mLow = 0; mTot = 0; mDone = 0;
    fork
      begin
        @(negedge clk);
        startStrobe = 1'b1; opcode = op;
        @(negedge clk);
        startStrobe = 1'b0;
        mBusyStart = busy; mFaultStart = busFault; mBitStart = resultBit;
        mTot = 1;
        while (!done) begin
          if (drv) mLow++;
          mTot++;
          @(negedge clk);
        end
        mDone = 1;
        @(negedge clk);
        if (done) mDone++;
      end
      begin
        if (devMode == 1 && holdUs > 0) begin
          while (!drv) @(negedge clk);
          devLow = 1'b1;
          repeat (holdUs * US) @(negedge clk);
          devLow = 1'b0;
        end else if (devMode == 2) begin
          while (!drv) @(negedge clk);
          while (drv) @(negedge clk);
          repeat (delayUs * US) @(negedge clk);
          devLow = 1'b1;
          repeat (lenUs * US) @(negedge clk);
          devLow = 1'b0;
        end
      end
      begin
        if (injectCyc > 0) begin
          repeat (injectCyc) @(negedge clk);
          startStrobe = 1'b1; opcode = 2'd0;
          @(negedge clk);
          startStrobe = 1'b0;
        end
      end
    join
  endtask

  task automatic testResetState();
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(done == 0, "R1", "done after reset", done, 0);
    chk(resultBit == 0, "R1", "resultBit after reset", resultBit, 0);
    chk(busFault == 0, "R1", "busFault after reset", busFault, 0);
    chk(drv == 0, "R1", "pad after reset", drv, 0);
  endtask

  task automatic testWriteOne();
    runOp(2'd1, 0, 0, 0, 0, 0);
    near("R2", "write-one low clocks", mLow, 6 * US, 3);
    near("R2", "write-one total clocks", mTot, 65 * US, 8);
    chk(mBusyStart == 1, "R11", "busy after start", mBusyStart, 1);
    chk(mDone == 1, "R11", "done width", mDone, 1);
    chk(busy == 0, "R11", "busy after done", busy, 0);
  endtask

  task automatic testWriteZero();
    runOp(2'd2, 0, 0, 0, 0, 0);
    near("R3", "write-zero low clocks", mLow, 60 * US, 3);
    near("R3", "write-zero total clocks", mTot, 65 * US, 8);
  endtask

  task automatic testReadTiming();
    runOp(2'd3, 0, 0, 0, 0, 0);
    near("R4", "read low clocks", mLow, 6 * US, 3);
    near("R4", "read total clocks", mTot, 60 * US, 8);
    chk(resultBit == 1, "R5", "read idle line", resultBit, 1);
  endtask

  task automatic testReadOne();
    runOp(2'd3, 1, 10, 0, 0, 0);
    chk(resultBit == 1, "R5", "read hold 10us", resultBit, 1);
    runOp(2'd3, 1, 13, 0, 0, 0);
    chk(resultBit == 1, "R5", "read hold 13us", resultBit, 1);
  endtask

  task automatic testReadZero();
    runOp(2'd3, 1, 17, 0, 0, 0);
    chk(resultBit == 0, "R6", "read hold 17us", resultBit, 0);
    runOp(2'd3, 1, 40, 0, 0, 0);
    chk(resultBit == 0, "R6", "read hold 40us", resultBit, 0);
    near("R6", "read total with long hold", mTot, 60 * US, 8);
  endtask

  task automatic testResetPresence();
    runOp(2'd0, 2, 0, 20, 100, 0);
    near("R7", "reset low clocks", mLow, 480 * US, 4);
    near("R7", "reset total clocks", mTot, 960 * US, 10);
    chk(resultBit == 0, "R7", "presence bit", resultBit, 0);
    chk(busFault == 0, "R7", "fault with presence", busFault, 0);
  endtask

  task automatic testResetEmpty();
    runOp(2'd0, 0, 0, 0, 0, 0);
    chk(resultBit == 1, "R8", "no device bit", resultBit, 1);
    chk(busFault == 0, "R8", "no device fault", busFault, 0);
  endtask

  task automatic testPreStuck();
    devLow = 1'b1;
    repeat (5) @(negedge clk);
    runOp(2'd0, 0, 0, 0, 0, 0);
    chk(busFault == 1, "R9", "stuck fault", busFault, 1);
    chk(resultBit == 1, "R9", "stuck presence invalid", resultBit, 1);
    chk(mLow == 0, "R9", "stuck pad driven", mLow, 0);
    chk(mTot <= 5, "R9", "stuck early end", mTot, 5);
    devLow = 1'b0;
    repeat (30) @(negedge clk);
    chk(busFault == 1, "R13", "fault held idle", busFault, 1);
    chk(resultBit == 1, "R13", "bit held idle", resultBit, 1);
    runOp(2'd1, 0, 0, 0, 0, 0);
    chk(mFaultStart == 0, "R13", "fault cleared at start", mFaultStart, 0);
    chk(mBitStart == 0, "R13", "bit cleared at start", mBitStart, 0);
  endtask

  task automatic testPostStuck();
    runOp(2'd0, 2, 0, 20, 580, 0);
    chk(busFault == 1, "R10", "late low fault", busFault, 1);
    chk(resultBit == 0, "R10", "late low presence", resultBit, 0);
    repeat (10) @(negedge clk);
  endtask

  task automatic testIgnoreStart();
    runOp(2'd2, 0, 0, 0, 0, 50);
    near("R12", "low clocks with extra start", mLow, 60 * US, 3);
    chk(mDone == 1, "R12", "done count", mDone, 1);
    repeat (20) @(negedge clk);
    chk(busy == 0, "R12", "no second op", busy, 0);
    chk(busFault == 0, "R12", "no reset fault", busFault, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    testWriteOne();
    testWriteZero();
    testReadTiming();
    testReadOne();
    testReadZero();
    testResetPresence();
    testResetEmpty();
    testPreStuck();
    testPostStuck();
    testIgnoreStart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule